// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up one slowly changing input line before the rest of the chip acts on it. The raw level first passes through a synchroniser into the system clock domain. A small state machine then decides when a change of level is real. The time a new level must hold is counted in pulses of a slow real-time tick of about 32.768 kHz. That tick reaches the block as a one-cycle enable in the system clock domain. A prescaler groups the ticks into units, and a programmed count sets how many units must pass.

A two-bit mode picks how glitches are treated. The filter can be off. It can delay changes in both directions. It can delay only rising changes, so that short low pulses pass at once. It can delay only falling changes, so that short high pulses pass at once. Each accepted change of the output comes with a one-cycle strobe.

The state machine has three states. `ST_FILL` follows the synchroniser output without filtering while the synchroniser fills after reset, then moves to `ST_IDLE`. `ST_IDLE` holds the output. It moves to `ST_QUAL` when the synchronised input differs from the output in a filtered direction. It accepts the change in the same step when the direction is unfiltered. `ST_QUAL` runs the timer. It moves back to `ST_IDLE` on expiry (accept), or when the input returns to the output level (restart). It also moves back to `ST_IDLE` when the mode stops filtering that direction (accept at once).

Top module: `pin_deglitch`

## Requirements
- R1: With mode 0 (bypass), a change of `raw_in` appears on `level_out` at the third rising clock edge that samples the new level, through a two-stage synchroniser and the output register.
- R2: During reset `level_out` and `edge_strobe` are 0. After reset is released, `level_out` takes the synchronised input with no debounce delay and without a strobe.
- R3: The time unit is picked by `{cfg_large, cfg_unit}`: 00 = 2 ticks, 01 = 8 ticks, 10 = 512 ticks, 11 = 2048 ticks. Only ticks that arrive while a change is being qualified count.
- R4: The qualification time is `cfg_count` units, where `cfg_count` is 4 bits wide (maximum 15) and a count of 0 acts as 1.
- R5: With mode 3 (strict), both rising and falling changes are accepted exactly on the tick that completes the programmed time, and not one tick earlier.
- R6: If the synchronised input returns to the current output level before the time runs out, the timer restarts. A later change then needs the full time again.
- R7: With mode 1, a falling change passes with the bypass latency of R1, while a rising change is qualified as in R5.
- R8: With mode 2, a rising change passes with the bypass latency of R1, while a falling change is qualified as in R5.
- R9: `edge_strobe` is high for exactly one clock per change of `level_out` after the reset fill, and it is low at all other times.
- R10: Ticks that arrive while the output is stable have no effect on the time a later change must hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable, one per real-time clock period |
| raw_in | input | 1 | Unsynchronised input level |
| cfg_mode | input | 2 | 0 bypass, 1 filter rising only, 2 filter falling only, 3 filter both |
| cfg_count | input | 4 | Number of time units (0 acts as 1) |
| cfg_unit | input | 1 | Low bit of time-unit select |
| cfg_large | input | 1 | High bit of time-unit select |
| level_out | output | 1 | Filtered level |
| edge_strobe | output | 1 | One-cycle pulse per accepted change |

## Verification
The hardest case to reach from the ports is the restart. The input must leave the output level, collect some but not all of its ticks, come back, and then leave again. Only the exact tick count of the second attempt shows whether the partial count was discarded. The directed stimulus brings the raw line back for a few clocks in the middle of a qualification. It then counts out the full tick total for the second attempt and checks that the output holds one tick short of that total. The same one-tick-short method checks every unit size, a count of zero, and the largest count.

// File: rtl/deb_pkg.sv
package deb_pkg;

    typedef enum logic [1:0] {
        DB_BYPASS    = 2'd0,
        DB_KEEP_LOW  = 2'd1,
        DB_KEEP_HIGH = 2'd2,
        DB_STRICT    = 2'd3
    } db_mode_e;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_IDLE = 2'd1,
        ST_QUAL = 2'd2
    } db_state_e;

    // True when a change toward 'new_high' must be qualified in this mode.
    function automatic logic needs_filter(db_mode_e mode, logic new_high);
        logic r;
        unique case (mode)
            DB_BYPASS:    r = 1'b0;
            DB_KEEP_LOW:  r = new_high;
            DB_KEEP_HIGH: r = ~new_high;
            DB_STRICT:    r = 1'b1;
            default:      r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/deb_timebase.sv
module deb_timebase #(
    parameter int CNT_W   = 4,
    parameter int U0_LOG2 = 1,
    parameter int U1_LOG2 = 3,
    parameter int U2_LOG2 = 9,
    parameter int U3_LOG2 = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rtc_tick,
    input  logic [1:0]       unit_sel,
    input  logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam int MAX_A = (U0_LOG2 > U1_LOG2) ? U0_LOG2 : U1_LOG2;
    localparam int MAX_B = (U2_LOG2 > U3_LOG2) ? U2_LOG2 : U3_LOG2;
    localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int PRE_W = (MAX_L < 1) ? 1 : MAX_L;

    logic [PRE_W-1:0] lim [4];
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] units;
    logic [CNT_W-1:0] target_m1;
    logic             unit_done;

    // Last prescaler value of each unit size.
    generate
        for (genvar g = 0; g < 4; g++) begin : g_lim
            localparam int LG = (g == 0) ? U0_LOG2 :
                                (g == 1) ? U1_LOG2 :
                                (g == 2) ? U2_LOG2 : U3_LOG2;
            assign lim[g] = PRE_W'((1 << LG) - 1);
        end
    endgenerate

    assign target_m1 = (count == '0) ? '0 : count - CNT_W'(1);
    assign unit_done = rtc_tick && (presc == lim[unit_sel]);
    assign expire    = !clear && unit_done && (units == target_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            units <= '0;
        end else if (clear) begin
            presc <= '0;
            units <= '0;
        end else if (rtc_tick) begin
            if (unit_done) begin
                presc <= '0;
                units <= units + CNT_W'(1);
            end else begin
                presc <= presc + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/deb_fsm.sv
module deb_fsm
    import deb_pkg::*;
#(
    parameter int FILL_CYC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sync_in,
    input  db_mode_e mode,
    input  logic     expire,
    output logic     level,
    output logic     strobe,
    output logic     qualifying
);
    localparam int FW = $clog2(FILL_CYC + 1);

    db_state_e state, nxt;
    logic [FW-1:0] fill_cnt;
    logic differs, filt, accept, load;

    assign differs = (sync_in != level);
    assign filt    = needs_filter(mode, sync_in);

    // Next state and accept decision.
    always_comb begin
        nxt    = state;
        accept = 1'b0;
        load   = 1'b0;
        unique case (state)
            ST_FILL: begin
                load = 1'b1;
                if (fill_cnt == FW'(FILL_CYC)) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (differs) begin
                    if (filt) nxt = ST_QUAL;
                    else      accept = 1'b1;
                end
            end
            ST_QUAL: begin
                if (!differs) begin
                    nxt = ST_IDLE;              // restart
                end else if (!filt || expire) begin
                    accept = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            default: nxt = ST_FILL;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_FILL && fill_cnt != FW'(FILL_CYC))
                fill_cnt <= fill_cnt + FW'(1);
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level  <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= accept;
            if (load)        level <= sync_in;
            else if (accept) level <= ~level;
        end
    end

    assign qualifying = (state == ST_QUAL);
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch
    import deb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int U0_LOG2     = 1,
    parameter int U1_LOG2     = 3,
    parameter int U2_LOG2     = 9,
    parameter int U3_LOG2     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             raw_in,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_unit,
    input  logic             cfg_large,
    output logic             level_out,
    output logic             edge_strobe
);
    logic sync_lvl, expire, qualifying;

    deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_lvl)
    );

    deb_timebase #(
        .CNT_W   (CNT_W),
        .U0_LOG2 (U0_LOG2),
        .U1_LOG2 (U1_LOG2),
        .U2_LOG2 (U2_LOG2),
        .U3_LOG2 (U3_LOG2)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!qualifying),
        .rtc_tick (rtc_tick),
        .unit_sel ({cfg_large, cfg_unit}),
        .count    (cfg_count),
        .expire   (expire)
    );

    deb_fsm #(.FILL_CYC(SYNC_STAGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_lvl),
        .mode       (db_mode_e'(cfg_mode)),
        .expire     (expire),
        .level      (level_out),
        .strobe     (edge_strobe),
        .qualifying (qualifying)
    );
endmodule

// File: rtl/deb_checker.sv
module deb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rtc_tick,
    input logic       raw_in,
    input logic [1:0] cfg_mode,
    input logic       level_out,
    input logic       edge_strobe
);
    logic [2:0] age;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end
    assign ready = (age >= 3'd5);

    // R9: one strobe per output change, none otherwise
    p_strobe_per_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (edge_strobe == (level_out != $past(level_out))));

    // R1: bypass follows the raw line three edges later
    p_bypass_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_mode == 2'd0 && $past(cfg_mode) == 2'd0)
        |-> (level_out == $past(raw_in, 3)));

    // R5: strict mode changes only on a tick
    p_strict_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_mode == 2'd3 && $past(cfg_mode) == 2'd3
         && level_out != $past(level_out)) |-> $past(rtc_tick));

    // R7: mode 1 rises only on a tick
    p_keep_low_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_mode == 2'd1 && $past(cfg_mode) == 2'd1 && $rose(level_out))
        |-> $past(rtc_tick));

    // R8: mode 2 falls only on a tick
    p_keep_high_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg_mode == 2'd2 && $past(cfg_mode) == 2'd2 && $fell(level_out))
        |-> $past(rtc_tick));

    // R2: outputs low while reset is held
    always_comb begin
        if (!rst_n) begin
            p_reset_low_r2: assert (!edge_strobe && !level_out);
        end
    end
endmodule

bind pin_deglitch deb_checker u_deb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtc_tick    (rtc_tick),
    .raw_in      (raw_in),
    .cfg_mode    (cfg_mode),
    .level_out   (level_out),
    .edge_strobe (edge_strobe)
);

// File: tb/test_pin_deglitch.sv
module test_pin_deglitch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       raw_in = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] cfg_count = 4'd1;
    logic       cfg_unit = 1'b0;
    logic       cfg_large = 1'b0;
    logic       level_out, edge_strobe;

    int checks = 0;
    int errors = 0;
    int strobes_seen = 0;
    int strobes_exp = 0;
    int cycles = 0;
    logic cur = 1'b0;

    pin_deglitch i_pin_deglitch (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .raw_in(raw_in),
        .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_unit(cfg_unit),
        .cfg_large(cfg_large), .level_out(level_out), .edge_strobe(edge_strobe)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && edge_strobe) strobes_seen++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
        end
    endtask

    task automatic setcfg(int mode, int cnt, int unit_sel);
        @(negedge clk);
        cfg_mode  = 2'(mode);
        cfg_count = 4'(cnt);
        cfg_unit  = unit_sel[0];
        cfg_large = unit_sel[1];
    endtask

    // Change raw, expect acceptance on exactly 'n' ticks.
    task automatic qualify(string req, logic nv, int n);
        @(negedge clk) raw_in = nv;
        repeat (3) @(negedge clk);
        chk(req, level_out, cur);
        ticks(n - 1);
        chk(req, level_out, cur);
        ticks(1);
        chk(req, level_out, nv);
        chk(req, edge_strobe, 1);
        cur = nv;
        strobes_exp++;
        @(negedge clk);
        chk(req, edge_strobe, 0);
    endtask

    // Change raw, expect acceptance after the plain latency.
    task automatic pass_now(string req, logic nv);
        @(negedge clk) raw_in = nv;
        repeat (2) @(negedge clk);
        chk(req, level_out, cur);
        @(negedge clk);
        chk(req, level_out, nv);
        chk(req, edge_strobe, 1);
        cur = nv;
        strobes_exp++;
        @(negedge clk);
        chk(req, edge_strobe, 0);
    endtask

    task automatic t_reset();
        raw_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 reset level", level_out, 0);
        chk("R2 reset strobe", edge_strobe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 load after reset", level_out, 1);
        chk("R2 no strobe on load", strobes_seen, 0);
        cur = 1'b1;
    endtask

    task automatic t_bypass();
        setcfg(0, 1, 0);
        pass_now("R1 bypass fall", 1'b0);
        pass_now("R1 bypass rise", 1'b1);
    endtask

    task automatic t_strict();
        setcfg(3, 3, 0);
        qualify("R5 strict fall 3x2", 1'b0, 6);
        qualify("R5 strict rise 3x2", 1'b1, 6);
        setcfg(3, 1, 1);
        qualify("R3 unit 8", 1'b0, 8);
        setcfg(3, 1, 3);
        qualify("R3 unit 2048", 1'b1, 2048);
    endtask

    task automatic t_counts();
        setcfg(3, 0, 0);
        qualify("R4 count zero", 1'b0, 2);
        setcfg(3, 15, 0);
        qualify("R4 count 15", 1'b1, 30);
    endtask

    task automatic t_restart();
        setcfg(3, 2, 0);
        @(negedge clk) raw_in = 1'b0;
        repeat (3) @(negedge clk);
        ticks(3);
        @(negedge clk) raw_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 glitch rejected", level_out, 1);
        chk("R6 no strobe on glitch", strobes_seen, strobes_exp);
        qualify("R6 full time after restart", 1'b0, 4);
    endtask

    task automatic t_idle_ticks();
        setcfg(3, 2, 0);
        ticks(7);
        chk("R10 stable under ticks", level_out, cur);
        qualify("R10 idle ticks ignored", 1'b1, 4);
    endtask

    task automatic t_keep_low();
        setcfg(1, 1, 1);
        pass_now("R7 fall passes", 1'b0);
        qualify("R7 rise filtered", 1'b1, 8);
    endtask

    task automatic t_keep_high();
        setcfg(2, 2, 2);
        qualify("R8 fall filtered", 1'b0, 1024);
        pass_now("R8 rise passes", 1'b1);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_strict();
        t_counts();
        t_restart();
        t_idle_ticks();
        t_keep_low();
        t_keep_high();
        repeat (3) @(negedge clk);
        chk("R9 strobe count", strobes_seen, strobes_exp);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule